// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to eight device request lines and presents a single interrupt request to a processor. Each line has a fixed rank, and line 0 is the most urgent. A request is latched into a pending register. It is only considered for service while its bit in a processor-written enable register is set. The controller tracks every service that has started and not yet finished. It raises its interrupt output only when the most urgent enabled pending line outranks the most urgent service in progress. As a result, a running handler is preempted only by something strictly more urgent.

When the processor acknowledges, the controller moves the chosen line from pending to in-service. On the next cycle it returns an 8-bit vector equal to a programmable base plus the line index. It also returns the byte address of that vector's handler table entry, where each entry is four bytes. An end-of-service command retires the most urgent service in progress. The controller then falls back to the level that was preempted. Any waiting request that outranks that level is offered before the preempted level resumes.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset the pending and in-service state is empty, the enable register is all zero, the vector base is zero, and `intr` and `vec_valid` are low.
- R2: A high request line sets its pending bit whether or not it is enabled. A pending line whose enable bit is 0 never raises `intr`. It is offered as soon as its enable bit is set.
- R3: Among the enabled pending lines, the lowest index is selected.
- R4: An acknowledge taken while `intr` is high produces a one-cycle `vec_valid` in the following cycle. In that cycle `vec_out` is base plus the selected index, and `handler_addr` is `vec_out` multiplied by 4.
- R5: A taken acknowledge clears the selected pending bit and marks that line in service in the same cycle. `intr` then stays low unless a strictly more urgent enabled line is pending.
- R6: A pending enabled line whose index is lower than every in-service index raises `intr` during a service.
- R7: A request at the same or a lower rank than the most urgent service in progress is kept pending and is served after that service ends.
- R8: End-of-service clears only the most urgent in-service line. After that, `intr` is judged against the remaining in-service lines.
- R9: An acknowledge while `intr` is low changes nothing and gives no `vec_valid`.
- R10: The vector sum wraps modulo 256.
- R11: Writes to the enable register and to the vector base take effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Device request lines, bit i is line i |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | New enable register value, 1 enables a line |
| base_we | input | 1 | Write strobe for the vector base |
| base_wdata | input | 8 | New vector base |
| intr | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Processor acknowledge, one cycle |
| eos | input | 1 | End-of-service command, one cycle |
| vec_valid | output | 1 | Vector outputs valid this cycle |
| vec_out | output | 8 | Vector number of the acknowledged line |
| handler_addr | output | 10 | Handler table byte address, vector times 4 |

## Verification
The assertions assume that `ack` and `eos` are single-cycle pulses and are never raised in the same cycle. They also assume that end-of-service is only issued while some service is in progress. The stimulus follows these rules. It pulses each command for exactly one cycle and pairs every taken acknowledge with a later end-of-service. Request lines are dropped before the acknowledge that consumes them, so a level request is not latched again in that same cycle.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    localparam int LINES       = 8;
    localparam int VEC_W       = 8;
    localparam int ENTRY_SHIFT = 2;   // four bytes per handler entry

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_TAKE = 2'd1,
        CMD_DONE = 2'd2
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic take, input logic done);
        if (take)      return CMD_TAKE;
        else if (done) return CMD_DONE;
        else           return CMD_IDLE;
    endfunction
endpackage

// File: rtl/nirq_prio_enc.sv
module nirq_prio_enc #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nirq_vec_unit.sv
module nirq_vec_unit #(
    parameter int IW = 3,
    parameter int VW = 8,
    parameter int SH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic [VW-1:0] base_wdata,
    input  logic          take,
    input  logic [IW-1:0] take_idx,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out,
    output logic [VW+SH-1:0] handler_addr
);
    logic [VW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            vec_valid <= take;
            if (take) vec_out <= base_q + VW'(take_idx);
        end
    end

    assign handler_addr = {vec_out, {SH{1'b0}}};
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int N_LINES = nirq_pkg::LINES,
    parameter int V_W     = nirq_pkg::VEC_W,
    parameter int E_SH    = nirq_pkg::ENTRY_SHIFT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  irq_req,
    input  logic                en_we,
    input  logic [N_LINES-1:0]  en_wdata,
    input  logic                base_we,
    input  logic [V_W-1:0]      base_wdata,
    output logic                intr,
    input  logic                ack,
    input  logic                eos,
    output logic                vec_valid,
    output logic [V_W-1:0]      vec_out,
    output logic [V_W+E_SH-1:0] handler_addr
);
    localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic [N_LINES-1:0] pend_q, en_q, svc_q;
    logic [N_LINES-1:0] set_mask, clr_mask;
    logic               p_hit, s_hit, take;
    logic [IW-1:0]      p_idx, s_idx;
    cmd_e               cmd;

    nirq_prio_enc #(.N(N_LINES), .IW(IW)) u_pend_enc (
        .bits (pend_q & en_q),
        .hit  (p_hit),
        .idx  (p_idx)
    );

    nirq_prio_enc #(.N(N_LINES), .IW(IW)) u_svc_enc (
        .bits (svc_q),
        .hit  (s_hit),
        .idx  (s_idx)
    );

    // Raise only when the best enabled request outranks every running service.
    assign intr = p_hit && (!s_hit || (p_idx < s_idx));
    assign take = ack && intr;
    assign cmd  = decode_cmd(take, eos);

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (take)          set_mask = N_LINES'(1) << p_idx;
        if (eos && s_hit)  clr_mask = N_LINES'(1) << s_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            svc_q  <= '0;
        end else begin
            if (en_we) en_q <= en_wdata;
            pend_q <= (pend_q | irq_req) & ~set_mask;
            case (cmd)
                CMD_TAKE: svc_q <= (svc_q & ~clr_mask) | set_mask;
                CMD_DONE: svc_q <= svc_q & ~clr_mask;
                default:  svc_q <= svc_q;
            endcase
        end
    end

    nirq_vec_unit #(.IW(IW), .VW(V_W), .SH(E_SH)) u_vec (
        .clk          (clk),
        .rst          (rst),
        .base_we      (base_we),
        .base_wdata   (base_wdata),
        .take         (take),
        .take_idx     (p_idx),
        .vec_valid    (vec_valid),
        .vec_out      (vec_out),
        .handler_addr (handler_addr)
    );
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         intr,
    input logic         ack,
    input logic         eos,
    input logic         vec_valid,
    input logic [N-1:0] svc
);
    // R1: reset leaves no service running and no vector
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |=> (!vec_valid && svc == '0));

    // R4: a taken acknowledge yields a vector next cycle
    p_vec_follows_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && intr) |=> vec_valid);

    // R9: an acknowledge with intr low gives no vector
    p_ack_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (ack && !intr) |=> !vec_valid);

    // R5: a taken acknowledge adds exactly one in-service line
    p_svc_grow_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && intr && !eos) |=> ($countones(svc) == $countones($past(svc)) + 1));

    // R8: end-of-service retires exactly one in-service line
    p_svc_shrink_r8: assert property (@(posedge clk) disable iff (rst)
        (eos && !ack && svc != '0) |=> ($countones(svc) == $countones($past(svc)) - 1));
endmodule

bind nest_irq_ctrl nirq_chk #(.N(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .intr      (intr),
    .ack       (ack),
    .eos       (eos),
    .vec_valid (vec_valid),
    .svc       (svc_q)
);

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_req = '0;
    logic       en_we = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       base_we = 1'b0;
    logic [7:0] base_wdata = '0;
    logic       intr;
    logic       ack = 1'b0;
    logic       eos = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [9:0] handler_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .en_we(en_we), .en_wdata(en_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .intr(intr), .ack(ack), .eos(eos),
        .vec_valid(vec_valid), .vec_out(vec_out), .handler_addr(handler_addr)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: expect a vector, then pulse the acknowledge
    task automatic do_ack(input logic [7:0] exp_vec);
        exp_q.push_back(exp_vec);
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic pulse_eos();
        eos = 1'b1;
        step();
        eos = 1'b0;
    endtask

    task automatic request(input logic [7:0] lines);
        irq_req = lines;
        step();
        irq_req = '0;
    endtask

    // Monitor: compare every produced vector against the scoreboard (R4)
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R4/R9 unexpected vector actual=%0h expected=none", vec_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R4 vector", 32'(vec_out), 32'(e));
                chk("R4 handler address", 32'(handler_addr), 32'({e, 2'b00}));
            end
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 intr after reset", 32'(intr), 0);
        chk("R1 vec_valid after reset", 32'(vec_valid), 0);

        // R2: request latched while disabled, no intr
        request(8'h10);
        step();
        chk("R2 disabled pending keeps intr low", 32'(intr), 0);
        en_we = 1'b1; en_wdata = 8'hFF; base_we = 1'b1; base_wdata = 8'h40;
        step();
        en_we = 1'b0; base_we = 1'b0;
        chk("R11/R2 enable write raises intr", 32'(intr), 1);
        do_ack(8'h44);
        chk("R5 intr drops after ack", 32'(intr), 0);
        pulse_eos();
        chk("R8 idle after eos", 32'(intr), 0);

        // R3: several lines, lowest index first
        request(8'hA4);
        chk("R3 intr with lines 2,5,7", 32'(intr), 1);
        do_ack(8'h42);
        chk("R7 lower lines wait during service of 2", 32'(intr), 0);
        request(8'h01);
        chk("R6 line 0 preempts line 2", 32'(intr), 1);
        do_ack(8'h40);
        chk("R5 intr low in nested service", 32'(intr), 0);
        pulse_eos();
        chk("R8 back to line 2, line 5 still waits", 32'(intr), 0);
        pulse_eos();
        chk("R7 line 5 offered after line 2 ends", 32'(intr), 1);
        do_ack(8'h45);
        pulse_eos();
        chk("R7 line 7 offered next", 32'(intr), 1);
        do_ack(8'h47);
        pulse_eos();
        chk("R8 all services ended", 32'(intr), 0);

        // R7: equal rank held pending
        request(8'h08);
        do_ack(8'h43);
        request(8'h08);
        chk("R7 same line during its service", 32'(intr), 0);
        pulse_eos();
        chk("R7 same line offered after eos", 32'(intr), 1);
        do_ack(8'h43);
        pulse_eos();

        // R9: acknowledge while intr low
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk("R9 no vector on ignored ack", 32'(vec_valid), 0);
        chk("R9 intr still low", 32'(intr), 0);
        request(8'h40);
        do_ack(8'h46);
        pulse_eos();

        // R10/R11: base write and wrap
        base_we = 1'b1; base_wdata = 8'hFC;
        step();
        base_we = 1'b0;
        request(8'h40);
        do_ack(8'h02);
        pulse_eos();

        // R2: disable line 3, then enable it
        en_we = 1'b1; en_wdata = 8'hF7;
        step();
        en_we = 1'b0;
        request(8'h08);
        step();
        chk("R2 disabled line 3 pending, intr low", 32'(intr), 0);
        en_we = 1'b1; en_wdata = 8'hFF;
        step();
        en_we = 1'b0;
        chk("R2 line 3 offered once enabled", 32'(intr), 1);
        do_ack(8'hFF);
        pulse_eos();
        step();

        chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule